// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the receiving side of a serial flash interface. It watches an active-low chip select, a serial clock and one serial data input, all oversampled by a system clock. The first eight bits of each frame form an opcode. The opcode is compared against a table of supported codes supplied on input ports, and each table entry also says whether that command carries an address. For a supported command that carries an address, three more bytes follow. Only the low 21 bits of that address are kept.

When the opcode, and any address it needs, is complete, the block emits a single-cycle command-valid pulse with the opcode and address for a back-end. It starts nothing in three cases: the opcode is not in the table, the frame is cut short before it is complete, or the frame is finished and only trailing data follows. Raising chip select always returns the block to idle.

The controller has five states. IDLE means deselected. OPCODE shifts the opcode in. ADDR shifts the address in. EXEC means the command has been issued and the block waits for deselect. SKIP means the opcode was rejected. The transitions are:
- SELECT: IDLE to OPCODE when chip select falls.
- OP_REJECT: OPCODE to SKIP.
- OP_NOADDR: OPCODE to EXEC.
- OP_ADDR: OPCODE to ADDR.
- ADDR_FULL: ADDR to EXEC.
- DESELECT: any state to IDLE when chip select is high.

Top module: `spi_cmd_frontend`

## Requirements
- R1: While cs_n is high, and after reset, idle is 1 and cmd_valid is 0. While cs_n is low, idle is 0.
- R2: Serial bits are taken on the rising edge of sck only, most significant bit first. Frames work the same whether sck rests low or high between frames.
- R3: A table opcode whose op_addr_req bit is 0 gives exactly one cmd_valid pulse after its 8th bit. The pulse carries that opcode and cmd_addr of 0.
- R4: A table opcode whose op_addr_req bit is 1 gives exactly one cmd_valid pulse after the 24th address bit. cmd_addr equals address bits 20..0 of the big-endian 24-bit address, so bits 23..21 are dropped.
- R5: An opcode matching no entry of op_codes (entry i occupies bits 8i+7..8i) gives no cmd_valid for the rest of the frame, whatever bits follow.
- R6: If cs_n rises before the opcode and any required address are complete, no cmd_valid is produced and idle returns to 1.
- R7: cmd_valid lasts one clock cycle and occurs at most once per frame. Bits after a completed command have no effect.
- R8: Each frame starts with a clean bit count. A truncated or rejected frame does not disturb the decoding of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| si | input | 1 | Serial data input |
| op_codes | input | NUM_OPS*8 | Table of supported opcodes, entry i in bits 8i+7..8i |
| op_addr_req | input | NUM_OPS | Bit i set when entry i is followed by a 3-byte address |
| cmd_valid | output | 1 | One-cycle pulse when a command is fully received |
| cmd_opcode | output | 8 | Opcode of the issued command |
| cmd_addr | output | 21 | Kept address bits of the issued command |
| idle | output | 1 | High while the block is deselected |

## Verification
Random frames mix table opcodes with arbitrary bytes, random 24-bit addresses, both sck rest levels, random truncation points and random trailing bits. This separates the issue path from the reject path and the abort path. Directed frames cut the bit stream at 0, 7, 8 and 31 bits. These show whether the completion point is placed exactly at the opcode boundary and at the address boundary. Addresses with the top three bits set, such as 0xE12345 and 0xFFFFFF, show whether the discarded bits leak into cmd_addr. A rejected opcode followed by a stream that looks like a valid command shows whether the reject path really ignores the bus.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_EXEC   = 3'd3,
        ST_SKIP   = 3'd4
    } fe_state_t;

endpackage

// File: rtl/spi_sck_edge.sv
module spi_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic rise
);
    logic sck_q;

    // Resetting high avoids a false edge when sck rests high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b1;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q & ~cs_n;
endmodule

// File: rtl/spi_op_lookup.sv
module spi_op_lookup #(
    parameter int NUM_OPS = 4,
    parameter int OP_BITS = 8
) (
    input  logic [NUM_OPS*OP_BITS-1:0] op_codes,
    input  logic [NUM_OPS-1:0]         op_addr_req,
    input  logic [OP_BITS-1:0]         opcode,
    output logic                       hit,
    output logic                       needs_addr
);
    logic [NUM_OPS-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OPS; gi++) begin : g_entry
            assign match[gi] = (op_codes[gi*OP_BITS +: OP_BITS] == opcode);
        end
    endgenerate

    assign hit = |match;

    // Lowest matching index decides the address flag.
    always_comb begin
        needs_addr = 1'b0;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (match[i]) needs_addr = op_addr_req[i];
        end
    end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend #(
    parameter int NUM_OPS    = 4,
    parameter int OP_BITS    = 8,
    parameter int ADDR_BYTES = 3,
    parameter int ADDR_KEEP  = 21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sck,
    input  logic                       si,
    input  logic [NUM_OPS*OP_BITS-1:0] op_codes,
    input  logic [NUM_OPS-1:0]         op_addr_req,
    output logic                       cmd_valid,
    output logic [OP_BITS-1:0]         cmd_opcode,
    output logic [ADDR_KEEP-1:0]       cmd_addr,
    output logic                       idle
);
    import spi_fe_pkg::*;

    localparam int ADDR_BITS = ADDR_BYTES * 8;
    localparam int CNT_W     = $clog2(ADDR_BITS);
    localparam int SH_W      = ADDR_KEEP;

    fe_state_t state, state_nx;

    logic               rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [SH_W-2:0]    shreg;
    logic [SH_W-1:0]    shift_nx;
    logic [OP_BITS-1:0] op_full;
    logic [OP_BITS-1:0] op_latch;
    logic               in_op, op_done, addr_done;
    logic               op_hit, op_needs_addr;

    spi_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .rise  (rise)
    );

    spi_op_lookup #(
        .NUM_OPS (NUM_OPS),
        .OP_BITS (OP_BITS)
    ) u_lookup (
        .op_codes    (op_codes),
        .op_addr_req (op_addr_req),
        .opcode      (op_full),
        .hit         (op_hit),
        .needs_addr  (op_needs_addr)
    );

    // The shifter is only as wide as the kept address, so the dropped
    // upper address bits fall off its top.
    assign shift_nx  = {shreg, si};
    assign op_full   = shift_nx[OP_BITS-1:0];
    assign in_op     = (state == ST_IDLE) || (state == ST_OPCODE);
    assign op_done   = rise && in_op && (bit_cnt == CNT_W'(OP_BITS - 1));
    assign addr_done = rise && (state == ST_ADDR) && (bit_cnt == CNT_W'(ADDR_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                state_nx = ST_OPCODE;                  // SELECT
                if (op_done) begin
                    if (!op_hit)           state_nx = ST_SKIP;
                    else if (op_needs_addr) state_nx = ST_ADDR;
                    else                   state_nx = ST_EXEC;
                end
            end
            ST_OPCODE: begin
                if (op_done) begin
                    if (!op_hit)            state_nx = ST_SKIP;   // OP_REJECT
                    else if (op_needs_addr) state_nx = ST_ADDR;   // OP_ADDR
                    else                    state_nx = ST_EXEC;   // OP_NOADDR
                end
            end
            ST_ADDR: begin
                if (addr_done) state_nx = ST_EXEC;              // ADDR_FULL
            end
            ST_EXEC: state_nx = ST_EXEC;
            ST_SKIP: state_nx = ST_SKIP;
            default: state_nx = ST_IDLE;
        endcase
        if (cs_n) state_nx = ST_IDLE;                           // DESELECT
    end

    // Bit counter and shifter, cleared for every deselect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            op_latch <= '0;
        end else if (cs_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
        end else if (rise && (in_op || state == ST_ADDR)) begin
            shreg <= shift_nx[SH_W-2:0];
            if (op_done || addr_done) bit_cnt <= '0;
            else                      bit_cnt <= bit_cnt + 1'b1;
            if (op_done) op_latch <= op_full;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (op_done && op_hit && !op_needs_addr) begin
                cmd_valid  <= 1'b1;
                cmd_opcode <= op_full;
                cmd_addr   <= '0;
            end else if (addr_done) begin
                cmd_valid  <= 1'b1;
                cmd_opcode <= op_latch;
                cmd_addr   <= shift_nx;
            end
        end
    end

    assign idle = (state == ST_IDLE);
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic cmd_valid,
    input logic idle
);
    logic seen_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_pulse <= 1'b0;
        else if (cs_n)      seen_pulse <= 1'b0;
        else if (cmd_valid) seen_pulse <= 1'b1;
    end

    AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> idle); // R1
    AST_NO_VALID_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !cmd_valid); // R6
    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R7
    AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> !seen_pulse); // R7
    AST_BUSY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> !idle); // R3
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_valid (cmd_valid),
    .idle      (idle)
);

// File: tb/spi_cmd_frontend_bench.sv
module spi_cmd_frontend_bench;
    localparam int NUM_OPS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic [NUM_OPS*8-1:0] op_codes = {8'h9F, 8'h06, 8'h0B, 8'h03};
    logic [NUM_OPS-1:0]   op_addr_req = 4'b0011;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [20:0] cmd_addr;
    logic        idle;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide_pulses = 0;
    logic prev_valid = 1'b0;
    logic [7:0]  got_op = '0;
    logic [20:0] got_addr = '0;

    always #2 clk = ~clk;

    spi_cmd_frontend u_spi_cmd_frontend (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .si (si),
        .op_codes (op_codes), .op_addr_req (op_addr_req),
        .cmd_valid (cmd_valid), .cmd_opcode (cmd_opcode),
        .cmd_addr (cmd_addr), .idle (idle)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            pulses++;
            got_op = cmd_opcode;
            got_addr = cmd_addr;
            if (prev_valid) wide_pulses++;
        end
        prev_valid = cmd_valid;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic in_table(input logic [7:0] op);
        for (int i = 0; i < NUM_OPS; i++) if (op_codes[i*8 +: 8] == op) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic wants_addr(input logic [7:0] op);
        for (int i = 0; i < NUM_OPS; i++) if (op_codes[i*8 +: 8] == op) return op_addr_req[i];
        return 1'b0;
    endfunction

    // Send nbits of {op,addr} MSB first, then random trailing bits beyond 32.
    task automatic frame(input logic [7:0] op, input logic [23:0] addr, input int nbits,
                         input logic rest_hi, input string req);
        logic [31:0] word = {op, addr};
        int need = (in_table(op) && wants_addr(op)) ? 32 : 8;
        logic expect_pulse = in_table(op) && (nbits >= need);
        int p0;
        @(negedge clk); sck = rest_hi;
        repeat (2) @(negedge clk);
        p0 = pulses;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            sck = 1'b0;
            si = (b < 32) ? word[31-b] : 1'($urandom);
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
        end
        sck = rest_hi;
        repeat (2) @(negedge clk);
        check(idle == 1'b0, {req, " R1 idle low while selected"}, idle, 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(idle == 1'b1, {req, " R1 idle after deselect"}, idle, 1);
        check((pulses - p0) == (expect_pulse ? 1 : 0), {req, " pulse count"}, pulses - p0, expect_pulse ? 1 : 0);
        if (expect_pulse) begin
            check(got_op == op, {req, " opcode"}, got_op, op);
            check(got_addr == (need == 32 ? addr[20:0] : 21'd0), {req, " address"},
                  got_addr, need == 32 ? addr[20:0] : 21'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(idle == 1'b1 && cmd_valid == 1'b0, "R1 reset state", {idle, cmd_valid}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(idle == 1'b1 && cmd_valid == 1'b0, "R1 after reset release", {idle, cmd_valid}, 2'b10);

        frame(8'h06, 24'h0, 8, 1'b0, "R3 no-address command rest low");
        frame(8'h9F, 24'h0, 20, 1'b1, "R3 R7 no-address command with trailing bits rest high");
        frame(8'h03, 24'h0A5C3F, 32, 1'b0, "R4 R2 address command rest low");
        frame(8'h0B, 24'h15A5A5, 40, 1'b1, "R4 R2 R7 address command rest high");
        frame(8'h03, 24'hE12345, 32, 1'b0, "R4 upper bits dropped");
        frame(8'h0B, 24'hFFFFFF, 32, 1'b1, "R4 all ones address");
        frame(8'h5A, 24'h030000, 32, 1'b0, "R5 unsupported then command-like bits");
        frame(8'h03, 24'h000001, 32, 1'b0, "R8 frame after reject");
        frame(8'h06, 24'h0, 0, 1'b0, "R6 truncated at 0 bits");
        frame(8'h06, 24'h0, 7, 1'b1, "R6 truncated at 7 bits");
        frame(8'h03, 24'h123456, 8, 1'b0, "R6 truncated after opcode");
        frame(8'h0B, 24'h1FFFFF, 31, 1'b1, "R6 truncated at 31 bits");
        frame(8'h06, 24'h0, 8, 1'b0, "R8 frame after truncation");

        for (int n = 0; n < 70; n++) begin
            logic [7:0] op = ($urandom % 2) ? op_codes[($urandom % NUM_OPS)*8 +: 8] : 8'($urandom);
            logic [23:0] ad = 24'($urandom);
            int nb = ($urandom % 10 < 3) ? int'($urandom % 32) : 32 + int'($urandom % 10);
            frame(op, ad, nb, 1'($urandom), "R2 R3 R4 R5 R6 random frame");
        end

        check(wide_pulses == 0, "R7 pulse width one cycle", wide_pulses, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule